// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a simple 32-bit in-order core. Each clock cycle it computes the address of the next instruction from the current PC, the flow-control code produced by the decoder, the immediate fields of the current instruction, the value read from the source register, and the equality flag from the register comparator. It then loads that address into the PC at the clock edge.

The supported flows are:

- **Sequential:** step to the next word.
- **Conditional branch:** jump on equal or on not-equal. The branch is relative to the address of the following instruction.
- **Absolute jump:** stays inside the current 256 MB region. One variant also produces a link value for the return-address register.
- **Register-indirect jump:** goes to the address held in the source register.

A register-indirect target that is not word aligned is refused. The unit flags it, and the PC holds its value. A synchronous reset places the PC at a start address chosen by parameter.

Top module: `pc_sequencer`

## Requirements
- R1: With `flow_sel` = 0 (sequential), or with one of the unused codes 6 and 7, the PC after the clock edge equals PC+4, wrapping modulo 2^32.
- R2: A taken branch loads PC+4 + (sign-extended `br_off` × 4). `br_off` is a 16-bit two's-complement word offset, so offset N lands N+1 instructions after the branch.
- R3: `flow_sel` = 1 branches when `regs_equal` is 1, and `flow_sel` = 2 branches when `regs_equal` is 0. A branch that is not taken loads PC+4.
- R4: `flow_sel` = 3 (jump) and `flow_sel` = 4 (jump-and-link) load {PC[31:28], `jmp_idx`[25:0], 2'b00}. The top four PC bits are therefore kept.
- R5: `link_addr` always shows PC+4 of the current PC. `link_we` is 1 in exactly the cycles where `flow_sel` = 4 and reset is low.
- R6: `flow_sel` = 5 (register jump) with `rs_val`[1:0] = 0 loads `rs_val` into the PC.
- R7: `flow_sel` = 5 with `rs_val`[1:0] ≠ 0 drives `misalign` high in that cycle, and the PC keeps its value across the edge. In all other cases `misalign` is low.
- R8: While `rst` is high at a clock edge, the PC loads `START_ADDR`. While `rst` is high, `link_we` and `misalign` stay low whatever the flow code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flow_sel | input | 3 | Flow code: 0 sequential, 1 branch-equal, 2 branch-not-equal, 3 jump, 4 jump-and-link, 5 register jump |
| br_off | input | 16 | Branch word offset, two's complement |
| jmp_idx | input | 26 | Absolute jump word index |
| rs_val | input | 32 | Source register value for the register jump |
| regs_equal | input | 1 | High when the two compared registers are equal |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Return address, PC+4 |
| link_we | output | 1 | Write enable for the return-address register |
| misalign | output | 1 | Register jump target not word aligned |

## Verification
Two cases need care because two functions act in the same cycle:

- **Jump-and-link:** the link output and the jump target both come from the same PC. The bench therefore compares `link_addr` and `link_we` before the edge, and the new PC after it, against values worked out from the PC the model held before that edge.
- **Misaligned register jump:** the flag and the hold of the PC must occur together. The sweep pairs every flow code with every value of the low two bits of `rs_val`, which provokes both. The bench then checks that `misalign` rises only for the register jump and that the PC after the edge equals the PC before it.

Reset is also applied while a jump-and-link and a misaligned register jump are presented. The bench confirms that both side outputs stay low during reset.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_BEQ  = 3'd1,
    FLOW_BNE  = 3'd2,
    FLOW_JMP  = 3'd3,
    FLOW_JAL  = 3'd4,
    FLOW_JREG = 3'd5
  } flow_e;
endpackage

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur,
  output logic [XLEN-1:0] nxt
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  assign nxt = cur + STEP;
endmodule

// File: rtl/pcseq_branch.sv
module pcseq_branch #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] off,
  input  logic             on_eq,
  input  logic             on_ne,
  input  logic             eq,
  output logic             taken,
  output logic [XLEN-1:0]  target
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  logic [XLEN-1:0] disp;
  assign disp   = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
  assign target = base + disp;
  assign taken  = (on_eq & eq) | (on_ne & ~eq);
endmodule

// File: rtl/pcseq_jump.sv
module pcseq_jump #(
  parameter int XLEN  = 32,
  parameter int TGT_W = 26
) (
  input  logic [XLEN-TGT_W-3:0] region,
  input  logic [TGT_W-1:0]      idx,
  output logic [XLEN-1:0]       target
);
  assign target = {region, idx, 2'b00};
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              OFF_W      = 16,
  parameter int              TGT_W      = 26,
  parameter logic [XLEN-1:0] START_ADDR = 32'h0040_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       flow_sel,
  input  logic [OFF_W-1:0] br_off,
  input  logic [TGT_W-1:0] jmp_idx,
  input  logic [XLEN-1:0]  rs_val,
  input  logic             regs_equal,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  link_addr,
  output logic             link_we,
  output logic             misalign
);
  localparam int REGION_W = XLEN - TGT_W - 2;

  flow_e           kind;
  logic [XLEN-1:0] pc_r, seq_pc, br_tgt, jmp_tgt, nxt;
  logic            br_taken, bad_jr;

  assign kind = flow_e'(flow_sel);

  pcseq_incr #(.XLEN(XLEN)) u_incr (.cur(pc_r), .nxt(seq_pc));

  pcseq_branch #(.XLEN(XLEN), .OFF_W(OFF_W)) u_branch (
    .base(seq_pc), .off(br_off),
    .on_eq(kind == FLOW_BEQ), .on_ne(kind == FLOW_BNE),
    .eq(regs_equal), .taken(br_taken), .target(br_tgt)
  );

  pcseq_jump #(.XLEN(XLEN), .TGT_W(TGT_W)) u_jump (
    .region(pc_r[XLEN-1 -: REGION_W]), .idx(jmp_idx), .target(jmp_tgt)
  );

  assign bad_jr = (kind == FLOW_JREG) && (rs_val[1:0] != 2'b00);

  always_comb begin
    nxt = seq_pc;
    unique case (kind)
      FLOW_BEQ, FLOW_BNE: if (br_taken) nxt = br_tgt;
      FLOW_JMP, FLOW_JAL: nxt = jmp_tgt;
      FLOW_JREG:          nxt = bad_jr ? pc_r : rs_val;
      default:            nxt = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_r <= START_ADDR;
    else     pc_r <= nxt;
  end

  assign pc        = pc_r;
  assign link_addr = seq_pc;
  assign link_we   = ~rst & (kind == FLOW_JAL);
  assign misalign  = ~rst & bad_jr;

  // R1: sequential step
  assert_seq_step_R1: assert property (@(posedge clk) disable iff (rst)
    (flow_sel == 3'd0) |=> (pc == $past(pc) + 32'd4));
  // R4: jumps keep the region bits and word alignment
  assert_jump_region_R4: assert property (@(posedge clk) disable iff (rst)
    (flow_sel == 3'd3 || flow_sel == 3'd4) |=>
      (pc[XLEN-1 -: REGION_W] == $past(pc[XLEN-1 -: REGION_W]) && pc[1:0] == 2'b00));
  // R5: link write only for jump-and-link
  assert_link_only_jal_R5: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (flow_sel == 3'd4));
  // R7: a refused register jump holds the PC
  assert_misalign_hold_R7: assert property (@(posedge clk) disable iff (rst)
    misalign |=> $stable(pc));
  // R8: reset loads the start address
  assert_reset_start_R8: assert property (@(posedge clk)
    rst |=> (pc == START_ADDR));
  // R8: side outputs quiet during reset
  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |-> (!link_we && !misalign));
endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  localparam logic [31:0] START = 32'hA000_0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  flow_sel = 3'd0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_idx = '0;
  logic [31:0] rs_val = '0;
  logic        regs_equal = 1'b0;
  logic [31:0] pc, link_addr;
  logic        link_we, misalign;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  pc_sequencer #(.START_ADDR(START)) i_pc_sequencer (
    .clk(clk), .rst(rst), .flow_sel(flow_sel), .br_off(br_off),
    .jmp_idx(jmp_idx), .rs_val(rs_val), .regs_equal(regs_equal),
    .pc(pc), .link_addr(link_addr), .link_we(link_we), .misalign(misalign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] k, input logic [15:0] off,
                       input logic [25:0] ji, input logic [31:0] rv, input logic eq);
    logic [31:0] e_next, plus4;
    logic        e_bad;
    string       tag;
    @(negedge clk);
    flow_sel = k; br_off = off; jmp_idx = ji; rs_val = rv; regs_equal = eq;
    #1;
    plus4 = model_pc + 32'd4;
    e_bad = (k == 3'd5) && (rv[1:0] != 2'b00);
    case (k)
      3'd1: begin e_next = eq  ? plus4 + {{14{off[15]}}, off, 2'b00} : plus4; tag = "R2/R3 beq"; end
      3'd2: begin e_next = !eq ? plus4 + {{14{off[15]}}, off, 2'b00} : plus4; tag = "R2/R3 bne"; end
      3'd3, 3'd4: begin e_next = {model_pc[31:28], ji, 2'b00}; tag = "R4 jump"; end
      3'd5: begin e_next = e_bad ? model_pc : rv; tag = e_bad ? "R7 hold" : "R6 jreg"; end
      default: begin e_next = plus4; tag = "R1 seq"; end
    endcase
    chk("R5 link_addr", link_addr, plus4);
    chk("R5 link_we", {31'd0, link_we}, {31'd0, k == 3'd4});
    chk("R7 misalign", {31'd0, misalign}, {31'd0, e_bad});
    @(posedge clk);
    #1;
    chk(tag, pc, e_next);
    model_pc = e_next;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [15:0] offs [6];
    offs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0123};
    // R8: reset while a jump-and-link is presented
    flow_sel = 3'd4;
    repeat (2) @(posedge clk);
    #1;
    chk("R8 reset pc", pc, START);
    chk("R8 link_we low in reset", {31'd0, link_we}, 32'd0);
    // R8: reset while a misaligned register jump is presented
    @(negedge clk);
    flow_sel = 3'd5; rs_val = 32'h0000_0003;
    #1;
    chk("R8 misalign low in reset", {31'd0, misalign}, 32'd0);
    @(posedge clk); #1;
    chk("R8 reset pc held", pc, START);
    @(negedge clk);
    rst = 1'b0;
    model_pc = START;
    // sweep: every flow code x equality x offset x low rs bits
    for (int k = 0; k < 8; k++)
      for (int e = 0; e < 2; e++)
        for (int o = 0; o < 6; o++)
          for (int lb = 0; lb < 4; lb++)
            apply(3'(k), offs[o], 26'(32'h02AB_CDEF * (o + 1) + lb),
                  32'h5000_0000 + 32'(o) * 32'h0010_0000 + 32'(lb), 1'(e));
    // R1: wrap at the top of the address space
    apply(3'd5, 16'd0, 26'd0, 32'hFFFF_FFFC, 1'b0);
    apply(3'd0, 16'd0, 26'd0, 32'd0, 1'b0);
    // R4: jump from a high region with an all-ones index
    apply(3'd5, 16'd0, 26'd0, 32'hF000_0010, 1'b0);
    apply(3'd3, 16'd0, 26'h3FF_FFFF, 32'd0, 1'b0);
    apply(3'd4, 16'd0, 26'd0, 32'd0, 1'b0);
    // R8: reset mid-run returns to the start address
    @(negedge clk); rst = 1'b1; flow_sel = 3'd0;
    @(posedge clk); #1;
    chk("R8 reset mid-run", pc, START);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule